// File: doc/BRIEF.md
# Slave-serial FPGA configuration loader

This block loads a configuration image into a downstream FPGA through its slave-serial port. It drives the programming strobe, the configuration clock and the serial data line by toggling them in logic. It reads back the target's combined done/busy status pin. One start pulse runs the whole sequence. First the programming strobe goes low for a set time and is released. Then the loader gives the target a fixed time to clear its configuration memory and checks that the status pin reads low. Next it clocks out the payload bytes and gives the target a fixed settling time. Finally it checks that the status pin reads high.

Payload bytes arrive on a valid/ready byte stream, and a last flag marks the final byte. A byte is taken on any clock edge where valid and ready are both high. Ready is raised only while the loader waits for a byte, so the source must hold valid, data and last stable until that edge. After a byte is taken, ready stays low until all eight of its bits have been clocked out. After the last byte is taken, ready stays low until the end of the run. The result is held on the ok and error outputs, with a two-bit cause, until the next accepted start.

Every duration is a parameter in clock cycles: the programming pulse, the clear wait, the post-load wait and one quarter of a configuration-clock period (a slot). The status input passes through a synchronizer of `SYNC_STAGES` flops before it is used.

Top module: `sserial_cfg_loader`

## Requirements
- R1: Out of reset, and whenever `busy_o` is low, the outputs are `prog_o`=1, `cclk_o`=0, `din_o`=0 and `s_ready_o`=0. Right after reset, `ok_o`=0, `err_o`=0 and `err_cause_o`=0.
- R2: A start taken in idle raises `busy_o` and `csel_o` on the next edge. `prog_o` then stays low for exactly `PROG_CYCLES` cycles and is released high. `csel_o` stays high for as long as `busy_o` is high.
- R3: Exactly `CLEAR_CYCLES` cycles after `prog_o` goes high, the synchronized status is checked. If it reads low, `s_ready_o` goes high in the following cycle.
- R4: If the status reads high at the clear check, the run ends with `err_o`=1 and `err_cause_o`=2'b01. This happens `PROG_CYCLES+CLEAR_CYCLES` cycles after busy rose. No byte is taken and `cclk_o` never toggles.
- R5: Each byte is sent most significant bit first, with eight configuration clock pulses per byte. Each bit is placed on `din_o` before the rising edge of `cclk_o`.
- R6: Each bit takes four slots of `SLOT_CYCLES` cycles each: one slot low, two slots high, then one slot low. `din_o` does not change while `cclk_o` is high or at either of its edges.
- R7: `s_ready_o` is high only when the loader waits for a byte. It drops in the cycle after a byte is taken and stays low while that byte is clocked out. A byte that is held valid while ready is low is not taken.
- R8: After the last byte, the low slot of its final bit completes. The loader then waits `FINAL_CYCLES` cycles and checks the status. If it reads high, `busy_o` falls together with `ok_o`=1 and `err_cause_o`=2'b00.
- R9: If the status reads low at the final check, `busy_o` falls together with `err_o`=1 and `err_cause_o`=2'b10.
- R10: A start while `busy_o` is high has no effect: no further programming pulse, and the run timing does not change. A start taken in idle clears `ok_o`, `err_o` and `err_cause_o` on the same edge that raises `busy_o`.
- R11: `ok_o` and `err_o` are never high together. Each holds its value from the end of a run until the next start is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, used only in idle |
| s_valid_i | input | 1 | Payload byte valid |
| s_data_i | input | 8 | Payload byte |
| s_last_i | input | 1 | Marks the final payload byte |
| s_ready_o | output | 1 | Loader accepts a payload byte |
| cfg_done_i | input | 1 | Target done/busy status pin (asynchronous) |
| prog_o | output | 1 | Programming strobe, low pulse clears the target |
| cclk_o | output | 1 | Configuration clock |
| din_o | output | 1 | Configuration serial data |
| csel_o | output | 1 | Target select, high for the whole run |
| busy_o | output | 1 | A configuration run is in progress |
| ok_o | output | 1 | Last run finished successfully |
| err_o | output | 1 | Last run failed |
| err_cause_o | output | 2 | 00 none, 01 clear acknowledge missing, 10 target stays busy |

## Verification
A wrong slot or bit counter shows up at the pins within one configuration-clock period. It appears as a high phase whose length is not two slots, a data change at a clock edge, or a reassembled byte that differs from the byte sent. An off-by-one in the wait timer shifts the first ready after the programming release, or the fall of busy after the last clock pulse, by whole cycles. Those intervals are counted exactly. A bad sequencer state shows up either as a second programming pulse inside a run, or as a wrong flag or cause at the end of a run. The result is read on the cycle busy falls.

// File: rtl/sscfg_pkg.sv
package sscfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_CLEAR,
    ST_LOAD,
    ST_FINAL
  } cfg_state_t;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_NO_CLEAR = 2'b01,
    CAUSE_STUCK    = 2'b10
  } cfg_cause_t;

  localparam int BYTE_BITS = 8;

endpackage

// File: rtl/sscfg_wait_timer.sv
// Down-counter: after a load of N, zero_o is seen in the Nth cycle.
module sscfg_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         zero_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (load_i)       cnt <= len_i - W'(1);
    else if (cnt != '0)    cnt <= cnt - W'(1);
  end

  assign zero_o = (cnt == '0);
endmodule

// File: rtl/sscfg_bit_shifter.sv
// Sends one byte MSB first; each bit is four slots: low, high, high, low.
module sscfg_bit_shifter
  import sscfg_pkg::*;
#(
  parameter int SLOT_CYCLES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_i,
  input  logic [BYTE_BITS-1:0] byte_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 cclk_o,
  output logic                 din_o
);
  localparam int SW = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;
  localparam int BW = $clog2(BYTE_BITS);

  logic                 busy;
  logic [BYTE_BITS-1:0] shreg;
  logic [BW-1:0]        bits_left;
  logic [1:0]           slot;
  logic [SW-1:0]        scnt;
  logic                 slot_end;

  assign slot_end = (scnt == SW'(SLOT_CYCLES - 1));
  assign done_o   = busy && slot_end && (slot == 2'd3) && (bits_left == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      shreg     <= '0;
      bits_left <= '0;
      slot      <= '0;
      scnt      <= '0;
    end else if (!busy) begin
      if (load_i) begin
        busy      <= 1'b1;
        shreg     <= byte_i;
        bits_left <= BW'(BYTE_BITS - 1);
        slot      <= '0;
        scnt      <= '0;
      end
    end else if (!slot_end) begin
      scnt <= scnt + SW'(1);
    end else begin
      scnt <= '0;
      slot <= slot + 2'd1;
      if (slot == 2'd3) begin
        if (bits_left == '0) begin
          busy  <= 1'b0;
          shreg <= '0;
        end else begin
          bits_left <= bits_left - BW'(1);
          shreg     <= {shreg[BYTE_BITS-2:0], 1'b0};
        end
      end
    end
  end

  assign busy_o = busy;
  assign cclk_o = busy && ((slot == 2'd1) || (slot == 2'd2));
  assign din_o  = busy && shreg[BYTE_BITS-1];
endmodule

// File: rtl/sserial_cfg_loader.sv
module sserial_cfg_loader
  import sscfg_pkg::*;
#(
  parameter int PROG_CYCLES  = 250,
  parameter int CLEAR_CYCLES = 12_500_000,
  parameter int FINAL_CYCLES = 25_000_000,
  parameter int SLOT_CYCLES  = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       s_valid_i,
  input  logic [7:0] s_data_i,
  input  logic       s_last_i,
  output logic       s_ready_o,
  input  logic       cfg_done_i,
  output logic       prog_o,
  output logic       cclk_o,
  output logic       din_o,
  output logic       csel_o,
  output logic       busy_o,
  output logic       ok_o,
  output logic       err_o,
  output logic [1:0] err_cause_o
);
  localparam int MAX_A = (CLEAR_CYCLES > FINAL_CYCLES) ? CLEAR_CYCLES : FINAL_CYCLES;
  localparam int MAX_W = (MAX_A > PROG_CYCLES) ? MAX_A : PROG_CYCLES;
  localparam int TW    = $clog2(MAX_W + 1);

  cfg_state_t        state;
  logic              last_r, ok_r, err_r;
  cfg_cause_t        cause_r;
  logic [SYNC_STAGES-1:0] sync_q;
  logic              done_s;
  logic              tmr_load, tmr_zero;
  logic [TW-1:0]     tmr_len;
  logic              sh_busy, sh_done, accept;

  // status pin synchronizer
  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], cfg_done_i};
  end
  assign done_s = sync_q[SYNC_STAGES-1];

  assign s_ready_o = (state == ST_LOAD) && !sh_busy && !last_r;
  assign accept    = s_valid_i && s_ready_o;

  always_comb begin
    tmr_load = 1'b0;
    tmr_len  = TW'(FINAL_CYCLES);
    unique case (state)
      ST_IDLE: begin tmr_load = start_i;  tmr_len = TW'(PROG_CYCLES);  end
      ST_PROG: begin tmr_load = tmr_zero; tmr_len = TW'(CLEAR_CYCLES); end
      ST_LOAD: tmr_load = sh_done && last_r;
      default: ;
    endcase
  end

  sscfg_wait_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load_i(tmr_load), .len_i(tmr_len), .zero_o(tmr_zero)
  );

  sscfg_bit_shifter #(.SLOT_CYCLES(SLOT_CYCLES)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_i(accept), .byte_i(s_data_i),
    .busy_o(sh_busy), .done_o(sh_done), .cclk_o(cclk_o), .din_o(din_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      last_r  <= 1'b0;
      ok_r    <= 1'b0;
      err_r   <= 1'b0;
      cause_r <= CAUSE_NONE;
    end else begin
      unique case (state)
        ST_IDLE: if (start_i) begin
          state   <= ST_PROG;
          last_r  <= 1'b0;
          ok_r    <= 1'b0;
          err_r   <= 1'b0;
          cause_r <= CAUSE_NONE;
        end
        ST_PROG: if (tmr_zero) state <= ST_CLEAR;
        ST_CLEAR: if (tmr_zero) begin
          if (done_s) begin
            state   <= ST_IDLE;
            err_r   <= 1'b1;
            cause_r <= CAUSE_NO_CLEAR;
          end else begin
            state <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (accept) last_r <= s_last_i;
          if (sh_done && last_r) state <= ST_FINAL;
        end
        ST_FINAL: if (tmr_zero) begin
          state <= ST_IDLE;
          if (done_s) ok_r <= 1'b1;
          else begin
            err_r   <= 1'b1;
            cause_r <= CAUSE_STUCK;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state != ST_IDLE);
  assign csel_o      = (state != ST_IDLE);
  assign prog_o      = (state != ST_PROG);
  assign ok_o        = ok_r;
  assign err_o       = err_r;
  assign err_cause_o = cause_r;
endmodule

// File: rtl/sscfg_loader_chk.sv
module sscfg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_valid_i,
  input logic       s_ready_o,
  input logic       prog_o,
  input logic       cclk_o,
  input logic       din_o,
  input logic       csel_o,
  input logic       busy_o,
  input logic       ok_o,
  input logic       err_o,
  input logic [1:0] err_cause_o
);
  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (prog_o && !cclk_o && !din_o && !s_ready_o));

  // R2
  prog_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_o |-> (busy_o && csel_o));

  // R6
  din_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_o) |-> $stable(din_o));

  // R6
  din_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cclk_o) |-> $stable(din_o));

  // R7
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid_i && s_ready_o) |=> !s_ready_o);

  // R7
  ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready_o |-> (!cclk_o && prog_o && busy_o));

  // R10
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_o) |-> !$past(busy_o));

  // R11
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_o && err_o));

  // R11
  cause_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_o |-> err_cause_o == 2'b00) and (err_o |-> err_cause_o != 2'b00));
endmodule

bind sserial_cfg_loader sscfg_loader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
  .prog_o(prog_o), .cclk_o(cclk_o), .din_o(din_o), .csel_o(csel_o),
  .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o), .err_cause_o(err_cause_o)
);

// File: tb/sserial_cfg_loader_test.sv
`timescale 1ns/1ps
module sserial_cfg_loader_test;
  localparam int PROG  = 3;
  localparam int CLEAR = 20;
  localparam int FINAL = 30;
  localparam int SLOT  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic s_last = 1'b0;
  logic done_lvl = 1'b0;
  logic s_ready, prog, cclk, din, csel, busy, ok, err;
  logic [1:0] cause;

  always #2 clk = ~clk;

  sserial_cfg_loader #(
    .PROG_CYCLES(PROG), .CLEAR_CYCLES(CLEAR), .FINAL_CYCLES(FINAL),
    .SLOT_CYCLES(SLOT), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .s_valid_i(s_valid),
    .s_data_i(s_data), .s_last_i(s_last), .s_ready_o(s_ready),
    .cfg_done_i(done_lvl), .prog_o(prog), .cclk_o(cclk), .din_o(din),
    .csel_o(csel), .busy_o(busy), .ok_o(ok), .err_o(err), .err_cause_o(cause)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit expect_tail = 0;
  logic [7:0] exp_q[$];

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor state
  logic p_cclk = 0, p_prog = 1, p_busy = 0, p_din = 0, din_at_rise = 0;
  int hi_cnt = 0, bits = 0, clear_cnt = 0, prog_lo = 0, tail = 0, busy_cnt = 0;
  int prog_falls = 0, cclk_rises = 0;
  bit counting_clear = 0, ready_seen = 0;
  logic [7:0] acc = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!p_busy && busy) begin
        busy_cnt = 0; ready_seen = 0; cclk_rises = 0; prog_falls = 0;
      end
      if (busy) busy_cnt++;
      if (s_ready) ready_seen = 1;
      if (p_prog && !prog) begin prog_falls++; prog_lo = 0; end
      if (!prog) prog_lo++;
      if (!p_prog && prog) begin
        chk(prog_lo == PROG, "R2 prog low width", prog_lo, PROG);
        counting_clear = 1; clear_cnt = 1;
      end else if (counting_clear) begin
        if (s_ready) begin
          chk(clear_cnt == CLEAR, "R3 clear wait", clear_cnt, CLEAR);
          counting_clear = 0;
        end else if (!busy) counting_clear = 0;
        else clear_cnt++;
      end
      if (busy) chk(csel, "R2 csel during run", csel, 1);
      if (!p_cclk && cclk) begin
        cclk_rises++;
        chk(din == p_din, "R5 data before rise", din, p_din);
        din_at_rise = din; hi_cnt = 1;
        acc = {acc[6:0], din}; bits++;
        if (bits == 8) begin
          bits = 0;
          if (exp_q.size() == 0) chk(0, "R5 unexpected byte", acc, -1);
          else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            chk(acc == e, "R5 byte MSB first", acc, e);
          end
        end
      end else if (cclk) begin
        hi_cnt++;
        chk(din == din_at_rise, "R6 din stable high", din, din_at_rise);
      end
      if (p_cclk && !cclk) begin
        chk(hi_cnt == 2 * SLOT, "R6 high width", hi_cnt, 2 * SLOT);
        chk(din == din_at_rise, "R6 din stable fall", din, din_at_rise);
        tail = 1;
      end else if (busy && !cclk) tail++;
      if (s_ready && cclk) chk(0, "R7 ready while shifting", 1, 0);
      if (p_busy && !busy && expect_tail)
        chk(tail == SLOT + FINAL, "R8 post-load wait", tail, SLOT + FINAL);
      p_cclk = cclk; p_prog = prog; p_busy = busy; p_din = din;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic lst, input int gap);
    repeat (gap) @(negedge clk);
    s_valid = 1'b1; s_data = b; s_last = lst;
    exp_q.push_back(b);
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0; s_last = 1'b0; s_data = '0;
    chk(!s_ready, "R7 ready drops after accept", s_ready, 0);
  endtask

  task automatic wait_end();
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(prog && !cclk && !din && !busy && !s_ready, "R1 reset lines",
        {prog, cclk, din, busy, s_ready}, 5'b10000);
    chk(!ok && !err && cause == 0, "R1 reset result", {ok, err, cause}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Run A: good load, valid held early (back-pressure through prog and clear)
    done_lvl = 1'b0;
    expect_tail = 1;
    pulse_start();
    chk(busy && !prog, "R2 run starts", {busy, prog}, 2'b10);
    send_byte(8'hA5, 1'b0, 0);
    send_byte(8'h3C, 1'b0, 3);
    send_byte(8'hFF, 1'b0, 0);
    send_byte(8'h00, 1'b0, 7);
    send_byte(8'h81, 1'b1, 1);
    done_lvl = 1'b1;
    wait_end();
    chk(ok && !err && cause == 2'b00, "R8 success", {ok, err, cause}, 4'b1000);
    chk(exp_q.size() == 0, "R5 all bytes sent", exp_q.size(), 0);
    chk(prog_falls == 1, "R10 single pulse A", prog_falls, 1);
    repeat (10) @(negedge clk);
    chk(ok && !err, "R11 result held", {ok, err}, 2'b10);
    chk(prog && !cclk && !din, "R1 idle after run", {prog, cclk, din}, 3'b100);

    // Run B: status high at clear check
    expect_tail = 0;
    done_lvl = 1'b1;
    pulse_start();
    chk(!ok && !err && cause == 0, "R10 result cleared", {ok, err, cause}, 0);
    wait_end();
    chk(err && !ok && cause == 2'b01, "R4 clear ack missing", {ok, err, cause}, 4'b0101);
    chk(busy_cnt == PROG + CLEAR, "R4 run length", busy_cnt, PROG + CLEAR);
    chk(!ready_seen, "R4 no byte taken", ready_seen, 0);
    chk(cclk_rises == 0, "R4 no clocking", cclk_rises, 0);
    repeat (4) @(negedge clk);

    // Run C: status stays low, start retried mid-run
    expect_tail = 1;
    done_lvl = 1'b0;
    pulse_start();
    chk(!err && cause == 0, "R10 error cleared", {err, cause}, 0);
    send_byte(8'h5A, 1'b0, 2);
    pulse_start();
    send_byte(8'hC3, 1'b1, 0);
    pulse_start();
    wait_end();
    chk(err && !ok && cause == 2'b10, "R9 stays busy", {ok, err, cause}, 4'b0110);
    chk(prog_falls == 1, "R10 start ignored while busy", prog_falls, 1);
    chk(exp_q.size() == 0, "R5 bytes sent C", exp_q.size(), 0);
    repeat (5) @(negedge clk);
    chk(!busy && prog, "R10 no late restart", {busy, prog}, 2'b01);

    finished = 1;
    summary();
    $finish;
  end
endmodule